// File: doc/BRIEF.md
# Modem Status Change Tracker

This block watches four asynchronous, active-low modem handshake lines: carrier detect, ring indicator, data set ready and clear to send. It brings each line into the clock domain through a flop chain. It shows the present level of every line, inverted so that an asserted line reads as 1. Beside the levels it keeps four sticky change flags. All eight bits are packed into one read-only status word.

Software reads the word through a read strobe. A read leaves the word unchanged. Software clears change flags by writing ones to them. An interrupt request is raised while any change flag is set and the modem-status interrupt enable is on. The clear-to-send, data-set-ready and carrier-detect flags catch either edge of their line. The ring flag catches only the end of a ring, which is the moment the line stops being asserted.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset, with all modem pins held high (idle), `rd_data` reads 0 and `irq` is 0.
- R2: Status word layout: bit 7 carrier detect level, bit 6 ring level, bit 5 data set ready level, bit 4 clear to send level, bit 3 carrier detect change, bit 2 ring trailing edge, bit 1 data set ready change, bit 0 clear to send change. A level bit is 1 when its pin is low.
- R3: The change flags in bits 0, 1 and 3 set on every change of their line, whether the line is asserted or released.
- R4: Bit 2 sets only when the ring line goes from asserted (pin low) to released (pin high). Asserting the ring line leaves bit 2 unchanged.
- R5: A write with `wr_en` high clears each change flag whose position in `wr_data` holds 1. A flag whose position holds 0 keeps its value. Level bits are never changed by a write.
- R6: If a change event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: `irq` is 1 exactly when `msi_en` is 1 and at least one of status bits 3:0 is 1.
- R8: While `rd_en` is high, `rd_data` carries the status word in bits 7:0 and zeros in every bit above 7. Reading has no effect on any flag.
- R9: A pin change becomes visible in its level bit after the second rising clock edge that follows it. The matching change flag becomes visible after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_pin_n | input | 1 | Clear to send, asynchronous, active-low |
| dsr_pin_n | input | 1 | Data set ready, asynchronous, active-low |
| ri_pin_n | input | 1 | Ring indicator, asynchronous, active-low |
| dcd_pin_n | input | 1 | Carrier detect, asynchronous, active-low |
| rd_en | input | 1 | Read strobe; gates the status word onto rd_data |
| wr_en | input | 1 | Write strobe for flag clearing |
| wr_data | input | 4 | Write-one-to-clear mask for status bits 3:0 |
| msi_en | input | 1 | Modem-status interrupt enable |
| rd_data | output | 32 | Read data, status word in bits 7:0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench lines up a clearing write with the exact cycle in which a change flag sets. A design that let the clear win would lose that change, and the flag would read 0. The ring line is asserted and then released. A design that caught the wrong edge, or both edges, would show bit 2 too early or twice. Edge timing is sampled on the cycles before and after the expected update, so a missing or extra synchronizer stage shows up as a level bit or flag that is a cycle off. Writes of zero, repeated reads and random masks check that flags are neither lost nor cleared by accident, and that the interrupt follows the enable.

// File: rtl/mdm_pkg.sv
// Package: shared constants and types for the modem status tracker.
// Assumes the four lines are kept in one vector indexed by the constants below.
package mdm_pkg;
    localparam int unsigned NUM_LINES = 4;
    localparam int unsigned IDX_CTS   = 0;
    localparam int unsigned IDX_DSR   = 1;
    localparam int unsigned IDX_RI    = 2;
    localparam int unsigned IDX_DCD   = 3;
    localparam int unsigned WORD_W    = 2 * NUM_LINES;

    typedef enum logic [0:0] {
        EDGE_ANY  = 1'b0,
        EDGE_FALL = 1'b1
    } edge_mode_e;

    // Returns which edge of an internal (active-high) level raises a flag.
    function automatic edge_mode_e edge_mode_of(input int unsigned idx);
        return (idx == IDX_RI) ? EDGE_FALL : EDGE_ANY;
    endfunction
endpackage

// File: rtl/mdm_sync.sv
// Module: multi-stage flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is needed between bits.
module mdm_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw asynchronous pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
                    else        chain[s] <= async_in;
                end
            end else begin : g_next
                // Later stages: let any metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mdm_edge_detect.sv
// Module: per-line edge detector on synchronized active-high levels.
// Assumes input levels are already synchronous to clk; each line uses the
// edge mode given by the package function.
module mdm_edge_detect
    import mdm_pkg::*;
#(
    parameter int unsigned WIDTH = NUM_LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] change_evt
);
    logic [WIDTH-1:0] level_q;

    // Hold the previous sample of every level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_line
            if (edge_mode_of(i) == EDGE_FALL) begin : g_fall
                // Trailing edge only: asserted last cycle, released now.
                assign change_evt[i] = level_q[i] & ~level[i];
            end else begin : g_any
                // Either edge: level differs from last sample.
                assign change_evt[i] = level_q[i] ^ level[i];
            end
        end
    endgenerate
endmodule

// File: rtl/mdm_flag_bank.sv
// Module: sticky change flags with write-one-to-clear.
// Assumes a set event and a clear in the same cycle resolve as set.
module mdm_flag_bank #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_evt,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] clr_vec;

    // Qualify the clear mask with the write strobe.
    always_comb begin
        clr_vec = clr_en ? clr_mask : '0;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_flag
            // One sticky flag: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)           flags[i] <= 1'b0;
                else if (set_evt[i])  flags[i] <= 1'b1;
                else if (clr_vec[i])  flags[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/mdm_regport.sv
// Module: packs levels and flags into the status word, drives the read
// bus and the interrupt request. Purely combinational; reads have no side effect.
module mdm_regport
    import mdm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [NUM_LINES-1:0] levels,
    input  logic [NUM_LINES-1:0] flags,
    input  logic                 rd_en,
    input  logic                 msi_en,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 irq
);
    logic [WORD_W-1:0] status_word;

    // Levels in the upper nibble, change flags in the lower nibble.
    always_comb begin
        status_word = {levels, flags};
    end

    // Drive the read bus only while the read strobe is high.
    always_comb begin
        rd_data = '0;
        if (rd_en) rd_data[WORD_W-1:0] = status_word;
    end

    // Request an interrupt while enabled and any flag is pending.
    always_comb begin
        irq = msi_en & (|flags);
    end
endmodule

// File: rtl/modem_status_tracker.sv
// Module: top level of the modem status change tracker.
// Assumes the four pins are asynchronous, active-low and idle high.
module modem_status_tracker
    import mdm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_pin_n,
    input  logic              dsr_pin_n,
    input  logic              ri_pin_n,
    input  logic              dcd_pin_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [3:0]        wr_data,
    input  logic              msi_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [NUM_LINES-1:0] pins_n;
    logic [NUM_LINES-1:0] pins_sync_n;
    logic [NUM_LINES-1:0] levels;
    logic [NUM_LINES-1:0] change_evt;
    logic [NUM_LINES-1:0] flags;

    // Gather the pins into the package index order.
    always_comb begin
        pins_n          = '1;
        pins_n[IDX_CTS] = cts_pin_n;
        pins_n[IDX_DSR] = dsr_pin_n;
        pins_n[IDX_RI]  = ri_pin_n;
        pins_n[IDX_DCD] = dcd_pin_n;
    end

    mdm_sync #(
        .WIDTH   (NUM_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_n),
        .sync_out (pins_sync_n)
    );

    // Convert active-low pins to active-high levels.
    always_comb begin
        levels = ~pins_sync_n;
    end

    mdm_edge_detect #(
        .WIDTH (NUM_LINES)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (levels),
        .change_evt (change_evt)
    );

    mdm_flag_bank #(
        .WIDTH (NUM_LINES)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (change_evt),
        .clr_en   (wr_en),
        .clr_mask (wr_data),
        .flags    (flags)
    );

    mdm_regport #(
        .DATA_W (DATA_W)
    ) u_regport (
        .levels  (levels),
        .flags   (flags),
        .rd_en   (rd_en),
        .msi_en  (msi_en),
        .rd_data (rd_data),
        .irq     (irq)
    );
endmodule

// File: rtl/modem_status_tracker_chk.sv
// Module: assertion checker bound to the top; observes ports and the
// internal levels and flags driven by separate submodules.
module modem_status_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_data,
    input logic        msi_en,
    input logic        irq,
    input logic [3:0]  levels,
    input logic [3:0]  flags
);
    AST_IRQ_NEEDS_EN:   assert property (@(posedge clk) disable iff (!rst_n) irq |-> msi_en); // R7
    AST_IRQ_PENDING:    assert property (@(posedge clk) disable iff (!rst_n) (msi_en && (flags != 4'h0)) |-> irq); // R7
    AST_IRQ_NONE:       assert property (@(posedge clk) disable iff (!rst_n) (flags == 4'h0) |-> !irq); // R7
    AST_FLAG_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((($past(flags) & ~($past(wr_en) ? $past(wr_data) : 4'h0)) & ~flags) == 4'h0)); // R5
    AST_RING_TRAIL:     assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[2]) |-> (!$past(levels[2]) && $past(levels[2], 2))); // R4
    AST_CTS_CHANGE:     assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[0]) |-> ($past(levels[0]) != $past(levels[0], 2))); // R3
endmodule

bind modem_status_tracker modem_status_tracker_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .msi_en  (msi_en),
    .irq     (irq),
    .levels  (levels),
    .flags   (flags)
);

// File: tb/modem_status_tracker_bench.sv
// Bench: directed corner cases plus seeded random pin changes and writes,
// compared against a bench-side model of levels and flags.
module modem_status_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pins_n = 4'hF;   // index: 0 CTS, 1 DSR, 2 RI, 3 DCD
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_data = 4'h0;
    logic        msi_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [3:0] exp_lvl = 4'h0;
    logic [3:0] exp_flag = 4'h0;

    always #4 clk = ~clk;   // 125 MHz

    modem_status_tracker u_modem_status_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .cts_pin_n (pins_n[0]),
        .dsr_pin_n (pins_n[1]),
        .ri_pin_n  (pins_n[2]),
        .dcd_pin_n (pins_n[3]),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .msi_en    (msi_en),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // Model: flags after the lines move from old to new active-high levels.
    function automatic logic [3:0] next_flags(input logic [3:0] old_l, input logic [3:0] new_l,
                                              input logic [3:0] fl);
        logic [3:0] r = fl;
        for (int i = 0; i < 4; i++) begin
            if (i == 2) begin
                if (old_l[i] && !new_l[i]) r[i] = 1'b1;
            end else if (old_l[i] != new_l[i]) begin
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_word();
        return {24'h0, exp_lvl, exp_flag};
    endfunction

    task automatic check_all(input string req);
        rd_en = 1'b1;
        #1;
        check(req, rd_data, exp_word());
        check("R7", {31'h0, irq}, {31'h0, msi_en & (|exp_flag)});
        rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [3:0] np);
        pins_n = np;
        repeat (4) tick();
        exp_flag = next_flags(exp_lvl, ~np, exp_flag);
        exp_lvl = ~np;
    endtask

    task automatic do_write(input logic [3:0] mask);
        wr_en = 1'b1;
        wr_data = mask;
        tick();
        wr_en = 1'b0;
        wr_data = 4'h0;
        exp_flag = exp_flag & ~mask;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd12345;
        void'($urandom(seed));
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check_all("R1");
        check("R8", rd_data, 32'h0);   // rd_en low: bus is zero

        // R9 / R2 / R3: exact latency of CTS assertion.
        pins_n = 4'b1110;
        @(posedge clk); @(negedge clk);           // edge k
        rd_en = 1'b1; #1;
        check("R9", rd_data, 32'h00);
        @(posedge clk); @(negedge clk);           // edge k+1
        #1;
        check("R9", rd_data, 32'h10);
        @(posedge clk); @(negedge clk);           // edge k+2
        #1;
        check("R9", rd_data, 32'h11);
        rd_en = 1'b0;
        exp_lvl = 4'b0001; exp_flag = 4'b0001;
        check_all("R2");

        // R4: asserting RI leaves bit 2 clear; releasing it sets bit 2.
        set_pins(4'b1010);
        check_all("R4");
        check("R4", {31'h0, rd_data[2]}, 32'h0);
        set_pins(4'b1110);
        check_all("R4");

        // R3: DSR and DCD on both edges.
        do_write(4'hF);
        set_pins(4'b0100);
        check_all("R3");
        do_write(4'hF);
        set_pins(4'b1111);
        check_all("R3");

        // R5: write of zero keeps flags, write of one clears only that flag.
        do_write(4'h0);
        check_all("R5");
        do_write(4'b1000);
        check_all("R5");

        // R7: interrupt follows enable.
        msi_en = 1'b1; #1;
        check_all("R7");
        do_write(4'hF);
        check_all("R7");
        msi_en = 1'b0;

        // R8: repeated reads do not clear flags; upper bits zero.
        set_pins(4'b1101);
        rd_en = 1'b1;
        repeat (3) tick();
        check("R8", rd_data, exp_word());
        rd_en = 1'b0;

        // R6: clear write lands on the same edge that sets the flag.
        do_write(4'hF);
        pins_n = 4'b1111;                          // DSR released
        @(posedge clk); @(negedge clk);            // edge k
        @(posedge clk); @(negedge clk);            // edge k+1
        wr_en = 1'b1; wr_data = 4'b0010;
        @(posedge clk); @(negedge clk);            // edge k+2: set and clear
        wr_en = 1'b0; wr_data = 4'h0;
        exp_lvl = 4'b0000; exp_flag = 4'b0010;
        check_all("R6");

        // Random mix of pin changes and clearing writes (R3 R4 R5 R7).
        for (int n = 0; n < 300; n++) begin
            msi_en = $urandom() % 2;
            if (($urandom() % 2) == 0) set_pins(4'($urandom()));
            else                       do_write(4'($urandom()));
            check_all("R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule